// File: doc/BRIEF.md
# Tracker Queue Occupancy Monitor

This block sits beside a request tracker queue and watches only its allocate and deallocate strobes. From them it keeps a live count of valid entries. It also keeps four statistics counters: cycles spent full, cycles spent non-empty, accepted allocations, and an occupancy integral that adds the live entry count on every clock.

Software reads the occupancy integral and the allocation count and divides one by the other to get the average residency of an entry. The monitor does not do that division. It holds no queue data and makes no allocation decisions.

A strobe that cannot be honoured is reported and otherwise ignored. Such a strobe is an allocate while the queue is full with no matching release, or a release while it is empty with no matching allocate. A synchronous clear input zeroes the statistics without touching the live count, so a measurement window can be restarted while traffic is in flight.

Top module: `occ_monitor`

## Requirements
- R1: `level` rises by 1 on the clock after an accepted lone `alloc_stb`. It falls by 1 after an accepted lone `dealloc_stb`. It stays the same when both strobes are high together or when neither is high.
- R2: `full_cycles` grows by 1 on every clock whose starting `level` equals DEPTH.
- R3: `busy_cycles` grows by 1 on every clock whose starting `level` is non-zero.
- R4: `alloc_count` grows by 1 for each accepted allocate. A simultaneous allocate and release pair counts as an accepted allocate, even when the queue is full or empty.
- R5: `occ_sum` grows on every clock by the `level` value held at the start of that clock.
- R6: A lone `alloc_stb` while `level` equals DEPTH leaves `level` and `alloc_count` unchanged. It raises `err_overflow` for exactly the following cycle.
- R7: A lone `dealloc_stb` while `level` is 0 leaves `level` unchanged. It raises `err_underflow` for exactly the following cycle.
- R8: `stat_clr` high on a clock makes all four statistics read 0 after that clock, taking priority over any increment. `level` still follows R1 in that cycle.
- R9: While `rst_n` is low on a clock edge, `level`, all statistics and both error flags become 0.
- R10: `level` never exceeds DEPTH. Its width is the smallest that holds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_clr | input | 1 | Synchronous clear of the four statistics |
| alloc_stb | input | 1 | One entry allocated this cycle |
| dealloc_stb | input | 1 | One entry released this cycle |
| level | output | LVL_W | Live number of valid entries |
| full_cycles | output | CNT_W | Cycles with all entries valid |
| busy_cycles | output | CNT_W | Cycles with at least one entry valid |
| alloc_count | output | CNT_W | Accepted allocations |
| occ_sum | output | CNT_W | Running sum of `level` per cycle |
| err_overflow | output | 1 | Pulse: allocate refused because the queue was full |
| err_underflow | output | 1 | Pulse: release refused because the queue was empty |

## Verification
The strobe patterns are chosen to separate the cases. Lone allocates fill the queue to DEPTH and lone releases drain it to zero, which separates the full counter from the busy counter and shows the integral stepping by different amounts. Paired strobes are applied at empty, mid-level and full; they separate "pair leaves the level alone but counts an allocate" from the refused lone strobes at the same two boundaries, which must raise the error flags and leave the count unchanged. A clear is applied while entries are live, and again together with an allocate, to show the statistics restart while the live count is kept.

// File: rtl/occmon_pkg.sv
// Package occmon_pkg
// Shared definitions for the tracker occupancy monitor: the level step
// kinds and the index of each statistics counter.
// Assumes: nothing beyond standard SystemVerilog.
package occmon_pkg;

    // Direction the live entry count moves on a clock.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Slot of each statistic in the counter bank.
    localparam int STAT_FULL  = 0;
    localparam int STAT_BUSY  = 1;
    localparam int STAT_ALLOC = 2;
    localparam int STAT_OCC   = 3;
    localparam int NUM_STATS  = 4;

endpackage

// File: rtl/occ_level_tracker.sv
// Module occ_level_tracker
// Keeps the live count of valid tracker entries from the allocate and
// release strobes. It refuses a lone allocate at full and a lone release at
// empty, and reports each refusal as a one-cycle pulse on the next clock.
// Assumes: at most one allocate and one release per cycle; reset is
// synchronous and active low.
module occ_level_tracker
    import occmon_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_stb,
    input  logic             dealloc_stb,
    output logic [LVL_W-1:0] level,
    output logic             is_full,
    output logic             is_busy,
    output logic             alloc_ok,
    output logic             err_overflow,
    output logic             err_underflow
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    step_e step;
    logic  ovf_hit;
    logic  unf_hit;

    // Status of the count held at the start of the cycle.
    assign is_full = (level == LVL_MAX);
    assign is_busy = (level != '0);

    // Decide the step and spot refused strobes.
    always_comb begin
        ovf_hit  = alloc_stb & ~dealloc_stb & is_full;
        unf_hit  = dealloc_stb & ~alloc_stb & ~is_busy;
        alloc_ok = alloc_stb & (dealloc_stb | ~is_full);
        step     = STEP_HOLD;
        if (alloc_stb && !dealloc_stb && !is_full) begin
            step = STEP_UP;
        end else if (dealloc_stb && !alloc_stb && is_busy) begin
            step = STEP_DOWN;
        end
    end

    // Register the live count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            case (step)
                STEP_UP:   level <= level + LVL_W'(1);
                STEP_DOWN: level <= level - LVL_W'(1);
                default:   level <= level;
            endcase
        end
    end

    // Register the one-cycle refusal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            err_overflow  <= ovf_hit;
            err_underflow <= unf_hit;
        end
    end

endmodule

// File: rtl/occ_stat_counter.sv
// Module occ_stat_counter
// One wrapping statistics accumulator. It adds an increment on each enabled
// clock, and a synchronous clear wins over the add.
// Assumes: the increment is no wider than the counter.
module occ_stat_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_val,
    output logic [CNT_W-1:0] count
);

    // Accumulate, clear, or reset the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc_en) begin
            count <= count + CNT_W'(inc_val);
        end
    end

endmodule

// File: rtl/occ_monitor.sv
// Module occ_monitor
// Tracker queue occupancy monitor. It observes allocate and release strobes,
// keeps a live entry count, and drives four statistics: full cycles, busy
// cycles, accepted allocations, and the per-cycle occupancy integral.
// Assumes: the strobes are synchronous to clk; software performs any
// division of the occupancy integral by the allocation count.
module occ_monitor
    import occmon_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_clr,
    input  logic             alloc_stb,
    input  logic             dealloc_stb,
    output logic [LVL_W-1:0] level,
    output logic [CNT_W-1:0] full_cycles,
    output logic [CNT_W-1:0] busy_cycles,
    output logic [CNT_W-1:0] alloc_count,
    output logic [CNT_W-1:0] occ_sum,
    output logic             err_overflow,
    output logic             err_underflow
);

    logic             is_full;
    logic             is_busy;
    logic             alloc_ok;
    logic [NUM_STATS-1:0] stat_en;
    logic [LVL_W-1:0] stat_inc [NUM_STATS];
    logic [CNT_W-1:0] stat_val [NUM_STATS];

    occ_level_tracker #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_level (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_stb     (alloc_stb),
        .dealloc_stb   (dealloc_stb),
        .level         (level),
        .is_full       (is_full),
        .is_busy       (is_busy),
        .alloc_ok      (alloc_ok),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow)
    );

    // Route each statistic its enable and increment amount.
    always_comb begin
        stat_en[STAT_FULL]   = is_full;
        stat_inc[STAT_FULL]  = LVL_W'(1);
        stat_en[STAT_BUSY]   = is_busy;
        stat_inc[STAT_BUSY]  = LVL_W'(1);
        stat_en[STAT_ALLOC]  = alloc_ok;
        stat_inc[STAT_ALLOC] = LVL_W'(1);
        stat_en[STAT_OCC]    = 1'b1;
        stat_inc[STAT_OCC]   = level;
    end

    for (genvar i = 0; i < NUM_STATS; i++) begin : g_stat
        occ_stat_counter #(
            .CNT_W (CNT_W),
            .INC_W (LVL_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (stat_clr),
            .inc_en  (stat_en[i]),
            .inc_val (stat_inc[i]),
            .count   (stat_val[i])
        );
    end

    assign full_cycles = stat_val[STAT_FULL];
    assign busy_cycles = stat_val[STAT_BUSY];
    assign alloc_count = stat_val[STAT_ALLOC];
    assign occ_sum     = stat_val[STAT_OCC];

endmodule

// File: rtl/occ_monitor_chk.sv
// Module occ_monitor_chk
// Property checker for occ_monitor, attached through bind. It relates the
// strobes, the live count and the statistics across consecutive clocks.
// Assumes: the same parameters as the monitor it is bound to.
module occ_monitor_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat_clr,
    input logic             alloc_stb,
    input logic             dealloc_stb,
    input logic [LVL_W-1:0] level,
    input logic [CNT_W-1:0] full_cycles,
    input logic [CNT_W-1:0] busy_cycles,
    input logic [CNT_W-1:0] alloc_count,
    input logic [CNT_W-1:0] occ_sum,
    input logic             err_overflow,
    input logic             err_underflow
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX); // R10

    AST_LVL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc_stb && !dealloc_stb && level != LVL_MAX))
        |-> level == $past(level) + LVL_W'(1)); // R1

    AST_LVL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc_stb && dealloc_stb)) |-> $stable(level)); // R1

    AST_FULL_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stat_clr) && $past(level) == LVL_MAX)
        |-> full_cycles == $past(full_cycles) + CNT_W'(1)); // R2

    AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stat_clr) && $past(level) == '0)
        |-> $stable(busy_cycles)); // R3

    AST_OCC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stat_clr))
        |-> occ_sum == $past(occ_sum) + CNT_W'($past(level))); // R5

    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc_stb && !dealloc_stb && level == LVL_MAX))
        |-> (err_overflow && $stable(level))); // R6

    AST_UNF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dealloc_stb && !alloc_stb && level == '0))
        |-> (err_underflow && level == '0)); // R7

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stat_clr))
        |-> (full_cycles == '0 && busy_cycles == '0
             && alloc_count == '0 && occ_sum == '0)); // R8

endmodule

bind occ_monitor occ_monitor_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .LVL_W (LVL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stat_clr      (stat_clr),
    .alloc_stb     (alloc_stb),
    .dealloc_stb   (dealloc_stb),
    .level         (level),
    .full_cycles   (full_cycles),
    .busy_cycles   (busy_cycles),
    .alloc_count   (alloc_count),
    .occ_sum       (occ_sum),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/occ_monitor_test.sv
// Bench for occ_monitor: a table of strobe vectors walked by one loop,
// then directed tests for reset and clear. A reference model is built from
// the requirements, and the design's outputs are compared with it.
module occ_monitor_test;

    localparam int DEPTH = 4;
    localparam int CNT_W = 32;
    localparam int LVL_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stat_clr = 1'b0;
    logic             alloc_stb = 1'b0;
    logic             dealloc_stb = 1'b0;
    logic [LVL_W-1:0] level;
    logic [CNT_W-1:0] full_cycles, busy_cycles, alloc_count, occ_sum;
    logic             err_overflow, err_underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int m_lvl = 0, m_full = 0, m_busy = 0, m_alloc = 0, m_occ = 0;

    always #4 clk = ~clk; // 125 MHz

    occ_monitor #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr),
        .alloc_stb(alloc_stb), .dealloc_stb(dealloc_stb),
        .level(level), .full_cycles(full_cycles), .busy_cycles(busy_cycles),
        .alloc_count(alloc_count), .occ_sum(occ_sum),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    // Vector bits: {alloc, dealloc, exp_ovf, exp_unf, exp_level[2:0]}
    localparam logic [6:0] VEC [16] = '{
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd0},  // lone release at empty (R7)
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd1},
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
        {1'b1, 1'b1, 1'b0, 1'b0, 3'd2},  // pair mid-level (R1, R4)
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd4},
        {1'b1, 1'b0, 1'b1, 1'b0, 3'd4},  // lone alloc at full (R6)
        {1'b1, 1'b1, 1'b0, 1'b0, 3'd4},  // pair at full
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd3},
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd2},
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd2},
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd1},
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 3'd0},  // pair at empty
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd1}
    };

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance the reference model by one clock with the given inputs.
    task automatic model_step(input bit a, input bit d, input bit c);
        bit acc;
        acc = a && (d || m_lvl < DEPTH);
        if (c) begin
            m_full = 0; m_busy = 0; m_alloc = 0; m_occ = 0;
        end else begin
            m_full  += (m_lvl == DEPTH) ? 1 : 0;
            m_busy  += (m_lvl != 0) ? 1 : 0;
            m_alloc += acc ? 1 : 0;
            m_occ   += m_lvl;
        end
        if (a && !d && m_lvl < DEPTH) m_lvl++;
        else if (d && !a && m_lvl > 0) m_lvl--;
    endtask

    // Drive one clock of stimulus; return at the following falling edge.
    task automatic drive(input bit a, input bit d, input bit c);
        alloc_stb = a; dealloc_stb = d; stat_clr = c;
        model_step(a, d, c);
        @(posedge clk);
        @(negedge clk);
        alloc_stb = 1'b0; dealloc_stb = 1'b0; stat_clr = 1'b0;
    endtask

    task automatic check_stats(input string tag);
        check({"R2 ", tag}, "full_cycles", full_cycles, m_full);
        check({"R3 ", tag}, "busy_cycles", busy_cycles, m_busy);
        check({"R4 ", tag}, "alloc_count", alloc_count, m_alloc);
        check({"R5 ", tag}, "occ_sum",     occ_sum,     m_occ);
    endtask

    // Watchdog: an expired timer counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "level", level, 0);
        check("R9", "err_overflow", err_overflow, 0);
        check("R9", "err_underflow", err_underflow, 0);
        check_stats("reset");
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][6], VEC[i][5], 1'b0);
            check("R1", $sformatf("level vec %0d", i), level, VEC[i][2:0]);
            check("R10", "level bound", (level <= DEPTH), 1);
            check("R6", $sformatf("err_overflow vec %0d", i), err_overflow, VEC[i][4]);
            check("R7", $sformatf("err_underflow vec %0d", i), err_underflow, VEC[i][3]);
            check_stats($sformatf("vec %0d", i));
        end

        // R6/R7: pulse lasts one cycle only
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b0); // refused release at empty
        check("R7", "err_underflow set", err_underflow, 1);
        drive(1'b0, 1'b0, 1'b0);
        check("R7", "err_underflow one cycle", err_underflow, 0);

        // Build level 3, then clear the statistics with entries live
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        check("R8", "level kept over clear", level, 3);
        check("R8", "full_cycles cleared", full_cycles, 0);
        check("R8", "occ_sum cleared", occ_sum, 0);
        check_stats("after clear");

        // R8: clear together with an allocate; counters zero, level moves
        drive(1'b1, 1'b0, 1'b1);
        check("R8", "level with clear", level, 4);
        check("R8", "alloc_count clear wins", alloc_count, 0);
        drive(1'b0, 1'b0, 1'b0);
        check("R2", "full counts after clear", full_cycles, 1);
        check("R5", "occ after clear", occ_sum, 4);
        check_stats("post clear");

        // R9: reset mid-run returns everything to zero
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_lvl = 0; m_full = 0; m_busy = 0; m_alloc = 0; m_occ = 0;
        check("R9", "level after reset", level, 0);
        check_stats("mid reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule